// File: doc/BRIEF.md
# BCD Calendar Clock with Masked Alarm

This block keeps wall-clock time as six packed-BCD bytes: seconds, minutes, hours (24-hour), day of month, month (01 to 12) and a two-digit year (00 to 99). Software reads the year as an offset from 2000. The clock moves forward by one second on each single-cycle strobe on `sec_tick`, but only while the run bit in the control register is set. Every carry from seconds up to the year is worked out in the same cycle. All six bytes therefore change on one clock edge, and a reader that sees seconds at 00 can re-read the other fields and get a consistent set. Day rollover follows the length of the current month. February has 29 days when the two-digit year is a multiple of four.

A byte-wide register port lets software read and write each time byte, a matching set of alarm bytes, an alarm control byte and an interrupt-pending byte. The alarm control byte has one global enable and one compare-enable per field. A field whose compare bit is clear is not compared. When the global enable and at least one field enable are set and every enabled field equals the current time, a match is present. Only the first cycle of a match sets the pending bit, which drives the interrupt output. Software clears that bit by writing 1 to it.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the time reads 00:00:00 on day 01, month 01, year 00. The control, alarm-control, pending and all alarm bytes read 0x00, and `alarm_irq` is low.
- R2: Register map for reads and writes:
  - Time bytes sit at 0x0 (seconds), 0x1 (minutes), 0x2 (hours), 0x3 (day), 0x4 (month) and 0x5 (year).
  - The control byte is at 0x6. Its bit 0 is the run bit.
  - Alarm bytes sit at 0x8 to 0xD, in the same field order as the time bytes.
  - The alarm control byte is at 0xE. Bit 0 is the global enable, and bits 1 to 6 are the compare enables for seconds, minutes, hours, day, month and year.
  - The pending byte is at 0xF. Bit 0 is alarm-pending.
  - Unmapped addresses (0x7) read 0x00.
- R3: While the run bit is 0, `sec_tick` strobes leave every time byte unchanged. While it is 1, each strobe advances seconds by one in BCD, and the new value is readable in the cycle after the strobe edge.
- R4: Seconds 59 wraps to 00 and carries into minutes. Minutes 59 carries into hours, and hours 23 carries into the day. All affected bytes change on the same edge.
- R5: Day rolls over to 01 and increments the month after:
  - day 30 in months 04, 06, 09 and 11;
  - day 31 in the other months;
  - day 29 in February when the year is a multiple of four, and day 28 in February otherwise.
- R6: Month 12 rolls to 01 and increments the year. Year 99 wraps to 00.
- R7: A host write to a time byte in the same cycle as an active strobe loads the written value. That strobe is dropped for every field.
- R8: An alarm match requires three things: the global enable, at least one field compare enable, and equality on every enabled field. Fields whose enable is 0 are ignored.
- R9: A match sets pending one cycle after the time reaches the match, and `alarm_irq` follows pending. A match that persists does not set pending again after it has been cleared.
- R10: Writing 1 to bit 0 of the pending byte clears it. Writing 0 leaves it set.
- R11: Writing 0x00 to the alarm control byte stops all alarm matching, so a time equal to the alarm bytes does not set pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| alarm_irq | output | 1 | Alarm interrupt, equal to the pending bit |

## Verification
Directed settings sit just below each rollover so that every carry level is exercised:
- seconds into minutes, minutes into hours and hours into the day;
- 30-day and 31-day months, February in leap and non-leap years, and December of year 99.

A wrong month-length decode or a broken carry shows up as one specific wrong byte. Random valid start times, weighted toward field limits, are run for random numbers of strobes while the run bit toggles, and all six bytes are compared against a binary model kept in the bench.

The alarm is tried with three setups:
- a single enabled field, which shows that disabled fields are ignored;
- an added enabled field that does not match, which shows the compare is an AND;
- an alarm control byte of 0x00.

Clearing pending while the match still holds separates edge detection from level detection. A write to a time byte together with a strobe shows that the write wins.

// File: rtl/rtc_pkg.sv
// Shared constants and helpers for the BCD calendar clock.
// Assumes six time fields in the fixed order sec, min, hour, day, month, year.
package rtc_pkg;
    localparam int NF     = 6;
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DAY  = 3;
    localparam int F_MON  = 4;
    localparam int F_YEAR = 5;

    localparam logic [3:0] A_TIME0 = 4'h0;
    localparam logic [3:0] A_CTRL  = 4'h6;
    localparam logic [3:0] A_ALM0  = 4'h8;
    localparam logic [3:0] A_ACTRL = 4'hE;
    localparam logic [3:0] A_PEND  = 4'hF;

    // Add one to a packed-BCD byte (caller handles the field limit).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Last valid day (BCD) of a BCD month within a BCD two-digit year.
    function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
        logic leap;
        // Multiple of four: even tens with units 0/4/8, odd tens with units 2/6.
        if (!yr[4]) leap = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
        else        leap = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_calendar.sv
// Calendar counter: six packed-BCD fields advanced by one second per step.
// Assumes step is already qualified by the run bit; any host write mask
// drops the step for the whole cycle so all fields stay coherent.
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic [NF-1:0]       wr_mask,
    input  logic [7:0]          wr_data,
    output logic [NF-1:0][7:0]  time_q
);
    logic [NF-1:0][7:0] lim;
    logic [NF-1:0][7:0] flr;
    logic [NF-1:0][7:0] nxt;
    logic [NF:0]        carry;

    // Per-field wrap limit; the day limit follows month and year.
    always_comb begin
        lim[F_SEC]  = 8'h59;
        lim[F_MIN]  = 8'h59;
        lim[F_HOUR] = 8'h23;
        lim[F_DAY]  = last_day(time_q[F_MON], time_q[F_YEAR]);
        lim[F_MON]  = 8'h12;
        lim[F_YEAR] = 8'h99;
    end

    // Per-field value after wrapping, also the reset value.
    always_comb begin
        flr          = '0;
        flr[F_DAY]   = 8'h01;
        flr[F_MON]   = 8'h01;
    end

    assign carry[0] = step;

    genvar gi;
    generate
        for (gi = 0; gi < NF; gi++) begin : g_field
            // Ripple carry: a field moves when all lower fields are at their limit.
            assign carry[gi+1] = carry[gi] && (time_q[gi] == lim[gi]);
            assign nxt[gi] = !carry[gi]            ? time_q[gi] :
                             (time_q[gi] == lim[gi]) ? flr[gi] : bcd_inc(time_q[gi]);
        end
    endgenerate

    // Time registers: host write wins over the step in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= flr;
        end else if (|wr_mask) begin
            for (int i = 0; i < NF; i++)
                if (wr_mask[i]) time_q[i] <= wr_data;
        end else begin
            time_q <= nxt;
        end
    end

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !(|wr_mask)) |=> $stable(time_q)); // R3
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !(|wr_mask) && time_q[F_SEC] == 8'h59) |=> (time_q[F_SEC] == 8'h00)); // R4
    AST_MIN_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !(|wr_mask) && time_q[F_SEC] == 8'h59 && time_q[F_MIN] == 8'h59)
        |=> (time_q[F_MIN] == 8'h00 && time_q[F_SEC] == 8'h00)); // R4
    AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !(|wr_mask) && carry[F_YEAR] && time_q[F_YEAR] == 8'h99)
        |=> (time_q[F_YEAR] == 8'h00)); // R6
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (step && wr_mask[F_SEC]) |=> (time_q[F_SEC] == $past(wr_data))); // R7
endmodule

// File: rtl/rtc_alarm.sv
// Alarm bytes, alarm control and pending flag with edge-triggered set.
// Assumes control bit 0 is the global enable and bit i+1 enables field i.
module rtc_alarm
    import rtc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NF-1:0][7:0]  time_q,
    input  logic [NF-1:0]       alm_wr_mask,
    input  logic                actrl_wr,
    input  logic                pend_wr,
    input  logic [7:0]          wr_data,
    output logic [NF-1:0][7:0]  alm_q,
    output logic [NF:0]         actrl_q,
    output logic                pend_q
);
    logic [NF-1:0] field_ok;
    logic          hit;
    logic          hit_q;
    logic          hit_rise;
    logic          clr;

    genvar gi;
    generate
        for (gi = 0; gi < NF; gi++) begin : g_cmp
            // A disabled field counts as matching.
            assign field_ok[gi] = !actrl_q[gi+1] || (alm_q[gi] == time_q[gi]);
        end
    endgenerate

    assign hit      = actrl_q[0] && (|actrl_q[NF:1]) && (&field_ok);
    assign hit_rise = hit && !hit_q;
    assign clr      = pend_wr && wr_data[0];

    // Alarm field and control storage written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_q   <= '0;
            actrl_q <= '0;
        end else begin
            for (int i = 0; i < NF; i++)
                if (alm_wr_mask[i]) alm_q[i] <= wr_data;
            if (actrl_wr) actrl_q <= wr_data[NF:0];
        end
    end

    // Edge detector and pending flag; a new edge beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            hit_q <= hit;
            if (hit_rise)  pend_q <= 1'b1;
            else if (clr)  pend_q <= 1'b0;
        end
    end

    AST_PEND_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(hit && !hit_q)); // R9
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit_rise) |=> !pend_q); // R10
    AST_ZERO_CTRL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (actrl_wr && wr_data[NF:0] == '0) |=> !hit); // R11
    AST_KEEP_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clr) |=> pend_q); // R10
endmodule

// File: rtl/bcd_rtc_core.sv
// Top of the BCD calendar clock: address decode, run bit, read mux.
// Assumes ADDR_W >= 4; reads are combinational from bus_addr.
module bcd_rtc_core
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              alarm_irq
);
    logic [NF-1:0][7:0] time_q;
    logic [NF-1:0][7:0] alm_q;
    logic [NF:0]        actrl_q;
    logic               pend_q;
    logic               run_q;
    logic [NF-1:0]      time_wr;
    logic [NF-1:0]      alm_wr;
    logic               ctrl_wr;
    logic               actrl_wr;
    logic               pend_wr;

    genvar gi;
    generate
        for (gi = 0; gi < NF; gi++) begin : g_dec
            // Field write strobes for time and alarm bytes.
            assign time_wr[gi] = bus_wr && (bus_addr == ADDR_W'(A_TIME0) + ADDR_W'(gi));
            assign alm_wr[gi]  = bus_wr && (bus_addr == ADDR_W'(A_ALM0) + ADDR_W'(gi));
        end
    endgenerate

    assign ctrl_wr  = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
    assign actrl_wr = bus_wr && (bus_addr == ADDR_W'(A_ACTRL));
    assign pend_wr  = bus_wr && (bus_addr == ADDR_W'(A_PEND));

    // Run bit storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       run_q <= 1'b0;
        else if (ctrl_wr) run_q <= bus_wdata[0];
    end

    rtc_calendar u_cal (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (sec_tick && run_q),
        .wr_mask (time_wr),
        .wr_data (bus_wdata),
        .time_q  (time_q)
    );

    rtc_alarm u_alm (
        .clk         (clk),
        .rst_n       (rst_n),
        .time_q      (time_q),
        .alm_wr_mask (alm_wr),
        .actrl_wr    (actrl_wr),
        .pend_wr     (pend_wr),
        .wr_data     (bus_wdata),
        .alm_q       (alm_q),
        .actrl_q     (actrl_q),
        .pend_q      (pend_q)
    );

    // Read mux; unmapped addresses return zero.
    always_comb begin
        bus_rdata = 8'h00;
        for (int i = 0; i < NF; i++) begin
            if (bus_addr == ADDR_W'(A_TIME0) + ADDR_W'(i)) bus_rdata = time_q[i];
            if (bus_addr == ADDR_W'(A_ALM0) + ADDR_W'(i))  bus_rdata = alm_q[i];
        end
        if (bus_addr == ADDR_W'(A_CTRL))  bus_rdata = {7'd0, run_q};
        if (bus_addr == ADDR_W'(A_ACTRL)) bus_rdata = 8'(actrl_q);
        if (bus_addr == ADDR_W'(A_PEND))  bus_rdata = {7'd0, pend_q};
    end

    assign alarm_irq = pend_q;

    AST_IRQ_MIRRORS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_wr && bus_wdata[0] == 1'b0 && alarm_irq) |=> alarm_irq); // R10
    AST_RUN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !(|time_wr)) |=> $stable(time_q)); // R3
endmodule

// File: tb/bcd_rtc_core_tb.sv
// Self-checking bench: directed rollovers, alarm cases and random runs
// against a binary calendar model.
module bcd_rtc_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       alarm_irq;

    int n_vec = 0;
    int n_bad = 0;
    int ms, mm, mh, md, mmo, my;
    logic mrun = 1'b0;

    bcd_rtc_core #(.ADDR_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .alarm_irq(alarm_irq)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int mdays(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, int'(d), int'(exp));
    endtask

    task automatic model_tick();
        if (!mrun) return;
        ms++;
        if (ms == 60) begin ms = 0; mm++; end
        if (mm == 60) begin mm = 0; mh++; end
        if (mh == 24) begin mh = 0; md++; end
        if (md > mdays(mmo, my)) begin md = 1; mmo++; end
        if (mmo == 13) begin mmo = 1; my++; end
        if (my == 100) my = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        model_tick();
    endtask

    task automatic set_time(input int s, input int mi, input int h, input int d, input int mo, input int y);
        ms = s; mm = mi; mh = h; md = d; mmo = mo; my = y;
        wr(4'h0, to_bcd(s)); wr(4'h1, to_bcd(mi)); wr(4'h2, to_bcd(h));
        wr(4'h3, to_bcd(d)); wr(4'h4, to_bcd(mo)); wr(4'h5, to_bcd(y));
    endtask

    task automatic cmp_time(input string req);
        rd_chk(req, 4'h0, to_bcd(ms));  rd_chk(req, 4'h1, to_bcd(mm));
        rd_chk(req, 4'h2, to_bcd(mh));  rd_chk(req, 4'h3, to_bcd(md));
        rd_chk(req, 4'h4, to_bcd(mmo)); rd_chk(req, 4'h5, to_bcd(my));
    endtask

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R2 map readback
        ms = 0; mm = 0; mh = 0; md = 1; mmo = 1; my = 0;
        cmp_time("R1");
        rd_chk("R1", 4'h6, 8'h00); rd_chk("R1", 4'hE, 8'h00); rd_chk("R1", 4'hF, 8'h00);
        for (int i = 8; i < 14; i++) rd_chk("R1", 4'(i), 8'h00);
        chk("R1 irq", int'(alarm_irq), 0);
        rd_chk("R2 unmapped", 4'h7, 8'h00);
        wr(4'h9, 8'h45); rd_chk("R2 alarm min", 4'h9, 8'h45); wr(4'h9, 8'h00);

        // R3 stopped clock ignores strobes
        tick(); tick();
        cmp_time("R3 stopped");
        wr(4'h6, 8'h01); mrun = 1'b1;
        rd_chk("R2 ctrl", 4'h6, 8'h01);
        tick(); cmp_time("R3 advance");

        // R4 carry chain
        set_time(59, 59, 23, 15, 7, 30); tick(); cmp_time("R4 full carry");
        set_time(59, 12, 5, 3, 3, 3);    tick(); cmp_time("R4 sec carry");
        // R5 month lengths
        set_time(59, 59, 23, 30, 4, 10); tick(); cmp_time("R5 30-day");
        set_time(59, 59, 23, 30, 5, 10); tick(); cmp_time("R5 31-day mid");
        set_time(59, 59, 23, 28, 2, 24); tick(); cmp_time("R5 leap feb28");
        chk("R5 leap day", md, 29);
        tick(); tick(); cmp_time("R5 leap");
        set_time(59, 59, 23, 29, 2, 24); tick(); cmp_time("R5 leap feb29");
        set_time(59, 59, 23, 28, 2, 23); tick(); cmp_time("R5 common feb");
        chk("R5 march", mmo, 3);
        // R6 year rollover
        set_time(59, 59, 23, 31, 12, 41); tick(); cmp_time("R6 new year");
        set_time(59, 59, 23, 31, 12, 99); tick(); cmp_time("R6 century wrap");
        chk("R6 wrap year", my, 0);

        // R7 write and strobe in the same cycle
        set_time(20, 30, 1, 1, 1, 1);
        @(negedge clk);
        bus_addr = 4'h1; bus_wdata = 8'h44; bus_wr = 1'b1; sec_tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; sec_tick = 1'b0;
        mm = 44;
        cmp_time("R7 write wins");

        // R8/R9 alarm on seconds only; alarm minutes differ but are ignored
        wr(4'hF, 8'h01);
        set_time(29, 20, 10, 5, 6, 7);
        wr(4'h8, 8'h30); wr(4'h9, 8'h21); wr(4'hE, 8'h03);
        rd_chk("R2 actrl", 4'hE, 8'h03);
        chk("R9 before", int'(alarm_irq), 0);
        tick();
        chk("R9 same cycle", int'(alarm_irq), 0);
        @(negedge clk);
        chk("R8 sec match", int'(alarm_irq), 1);
        rd_chk("R2 pend", 4'hF, 8'h01);
        wr(4'hF, 8'h00); @(negedge clk);
        chk("R10 write zero", int'(alarm_irq), 1);
        wr(4'hF, 8'h01); @(negedge clk); @(negedge clk);
        chk("R9 no retrigger", int'(alarm_irq), 0);
        // R8 second enabled field mismatches
        wr(4'hE, 8'h07);
        set_time(29, 20, 10, 5, 6, 7);
        tick(); @(negedge clk); @(negedge clk);
        chk("R8 and-compare", int'(alarm_irq), 0);
        // R8 both enabled fields match
        set_time(29, 21, 10, 5, 6, 7);
        tick(); @(negedge clk);
        chk("R8 two fields", int'(alarm_irq), 1);
        wr(4'hF, 8'h01);
        // R11 zero control disables
        wr(4'h8, 8'h31); wr(4'hE, 8'h00);
        rd_chk("R11 readback", 4'hE, 8'h00);
        set_time(30, 21, 10, 5, 6, 7);
        tick(); @(negedge clk); @(negedge clk);
        chk("R11 quiet", int'(alarm_irq), 0);

        // R3/R4/R5/R6 random runs near limits with the run bit toggling
        for (int k = 0; k < 40; k++) begin
            int y, mo, d;
            y  = ($urandom % 2) ? 99 - int'($urandom % 3) : int'($urandom % 100);
            mo = ($urandom % 2) ? 12 : 1 + int'($urandom % 12);
            d  = ($urandom % 2) ? mdays(mo, y) : 1 + int'($urandom % mdays(mo, y));
            set_time(($urandom % 2) ? 50 + int'($urandom % 10) : int'($urandom % 60),
                     ($urandom % 2) ? 59 : int'($urandom % 60),
                     ($urandom % 2) ? 23 : int'($urandom % 24), d, mo, y);
            for (int t = 0; t < 1 + int'($urandom % 30); t++) begin
                if ($urandom % 8 == 0) begin
                    mrun = 1'($urandom % 2);
                    wr(4'h6, {7'd0, mrun});
                end
                if ($urandom % 2) @(negedge clk);
                tick();
            end
            cmp_time("R5 random");
        end
        report();
    end
endmodule